// File: doc/BRIEF.md
# Framebuffer Palette Fetch Sequencer

This block prepares one display frame for an LCD refresh engine. A start pulse makes it check the address window of the frame buffers. Unless the palette-load mode says otherwise, it then reads a 256-entry table of 16-bit colour words from the head of the active buffer into a local RAM. Bits 14:12 of the first word set the pixel depth. From that depth the block works out where pixel data begins and whether the buffer is large enough. If the frame passes, the block publishes the pixel base address, the depth, the packing format, the line step and the visible line range for the drawing engine that follows it.

Two frame buffers are supported. In dual mode, each frame that is shown hands the next frame to the other buffer. A stop pulse, or any error, drops the buffer selection. The next start therefore begins again at buffer 0. The drawing engine reads colour words from the local RAM through a dedicated read port.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, `busy`, `running`, `bufValid`, `activeBuf`, `syncErr`, `frameShown`, `paletteDone`, `condPulse` and `pixBase` are all 0.
- R2: With `loadMode` 0 or 3, a start issues exactly 256 one-cycle `memReq` reads. Read i uses byte address top+2*i of the active buffer, and each request waits for `memRdValid` before the next one. Word i is stored at RAM entry i, and `palRdData` returns the entry at `palRdAddr` one cycle after that address is presented. `paletteDone` pulses exactly once per load.
- R3: With `loadMode` 2, no reads are issued. The depth comes from the word 0 stored by the previous load, and the pixel offset is 0. With `loadMode` 1, a start is ignored: `busy` stays 0, no reads are issued and no frame is shown.
- R4: Depth code bits 14:12 of word 0 decode as follows: 1 gives `bppOut`=2, 2 gives 4, 3 gives 8, and 4 to 7 give 16. `fmt16` equals `tftMode` at 16 bpp and is 0 otherwise. Code 0 ends the frame with no `frameShown` and no error.
- R5: `pixBase` equals the active top address plus the offset. The offset is 0x200 for codes 3 to 7, 0x20 for codes 1 and 2, and 0 in `loadMode` 2.
- R6: `lineStep` equals width*bpp/8 bytes.
- R7: If offset + width*height*bpp/8 exceeds (bottom - top) + 2 of the active buffer, then `syncErr` is set and held until a stop, `running` and `bufValid` clear, and no frame is shown. A need exactly equal to size+2 is accepted.
- R8: Both addresses of buffer 0, and both of buffer 1 when `dualMode` is 1, must lie in [MEM_LO, MEM_HI]. Otherwise `condPulse[2]` pulses for one cycle, `running` and `bufValid` clear, and no read is issued. Buffer 1 addresses are not checked when `dualMode` is 0.
- R9: Each shown frame pulses `frameShown` and `condPulse[b]`, where b is the buffer used. In dual mode the active buffer then toggles; in single mode it stays 0.
- R10: A stop pulse makes `busy` 0 on the next cycle from any state, and clears `bufValid` and `syncErr`. The next start uses buffer 0. A stop wins over a start and over a frame completion that fall in the same cycle.
- R11: When `subEn` is 1 and `subFirst` is 1, `firstLine` is `subLines` and `lineCount` is the height. When `subEn` is 1 and `subFirst` is 0, `firstLine` is 0 and `lineCount` is `subLines`. When `subEn` is 0, `firstLine` is 0 and `lineCount` is the height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin one frame |
| stopPulse | input | 1 | Abort and drop buffer selection |
| loadMode | input | 2 | 1 = refresh off, 2 = skip palette load, else load |
| dualMode | input | 1 | Alternate between two buffers |
| tftMode | input | 1 | Selects 16-bit rather than 12-bit packing at 16 bpp |
| widthPx | input | DIM_W | Pixels per line |
| heightPx | input | DIM_W | Lines per frame |
| subEn | input | 1 | Subpanel line override enable |
| subFirst | input | 1 | Override gives first line rather than count |
| subLines | input | DIM_W | Subpanel line value |
| top0 | input | ADDR_W | Buffer 0 start byte address |
| bot0 | input | ADDR_W | Buffer 0 end byte address |
| top1 | input | ADDR_W | Buffer 1 start byte address |
| bot1 | input | ADDR_W | Buffer 1 end byte address |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | ADDR_W | Read byte address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 16 | Read data word |
| palRdAddr | input | 8 | Palette RAM read index |
| palRdData | output | 16 | Palette RAM read data |
| busy | output | 1 | Sequencer not idle |
| running | output | 1 | Controller on |
| bufValid | output | 1 | A buffer is selected |
| activeBuf | output | 1 | Buffer used by the next frame |
| frameShown | output | 1 | Pulse: frame accepted |
| paletteDone | output | 1 | Pulse: last palette word stored |
| condPulse | output | 3 | Pulses: bit0/1 buffer used, bit2 address error |
| syncErr | output | 1 | Frame region too small (sticky) |
| pixBase | output | ADDR_W | Pixel data start |
| bppOut | output | 5 | Bits per pixel |
| fmt16 | output | 1 | 16-bit packing at 16 bpp |
| lineStep | output | DIM_W+2 | Bytes per line |
| firstLine | output | DIM_W | First displayed line |
| lineCount | output | DIM_W | Displayed line count |

## Verification
Two events can fall in the same clock cycle here: a stop pulse and the cycle in which a frame would be accepted. A stop and a start can also coincide while the block is idle. The bench uses the no-load mode to make the frame length exactly four cycles. It raises the stop pulse in the final decision cycle, and it raises start and stop together when idle. It then judges the result at the ports: no `frameShown`, `busy` low, `bufValid` clear, and buffer 0 on the following start.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int PAL_ENTRIES = 256;
  localparam int PAL_DW      = 16;
  localparam int CODE_LSB    = 12;

  localparam logic [1:0] MODE_OFF    = 2'd1;
  localparam logic [1:0] MODE_NOLOAD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_DECODE,
    ST_SIZE
  } seqState_t;

  typedef struct packed {
    logic beginFrame;
    logic clrIdx;
    logic ldEntry;
    logic latchCalc;
    logic commit;
    logic errAddr;
    logic errSync;
    logic stopAll;
  } seqStrobe_t;

  typedef struct packed {
    logic addrOk;
    logic lastEntry;
    logic depthBad;
    logic tooBig;
  } seqStatus_t;

endpackage

// File: rtl/lcdseq_palram.sv
module lcdseq_palram #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    rdData <= store[rdAddr];
  end

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic [1:0] loadMode,
  input  logic       memRdValid,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       memReq,
  output logic       busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (stopPulse) begin
      strb.stopAll = 1'b1;
      nextState    = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startPulse && loadMode != MODE_OFF) begin
            strb.beginFrame = 1'b1;
            nextState       = ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!stat.addrOk) begin
            strb.errAddr = 1'b1;
            nextState    = ST_IDLE;
          end else if (loadMode == MODE_NOLOAD) begin
            nextState = ST_DECODE;
          end else begin
            strb.clrIdx = 1'b1;
            nextState   = ST_REQ;
          end
        end
        ST_REQ: nextState = ST_WAIT;
        ST_WAIT: begin
          if (memRdValid) begin
            strb.ldEntry = 1'b1;
            nextState    = stat.lastEntry ? ST_DECODE : ST_REQ;
          end
        end
        ST_DECODE: begin
          if (stat.depthBad) begin
            nextState = ST_IDLE;
          end else begin
            strb.latchCalc = 1'b1;
            nextState      = ST_SIZE;
          end
        end
        ST_SIZE: begin
          if (stat.tooBig) strb.errSync = 1'b1;
          else             strb.commit  = 1'b1;
          nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign memReq = (state == ST_REQ) && !stopPulse;
  assign busy   = (state != ST_IDLE);

  p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !busy);

  p_off_mode_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse && !stopPulse && loadMode == MODE_OFF) |=> !busy);

  p_single_request_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

endmodule

// File: rtl/lcdseq_dp.sv
module lcdseq_dp
  import lcdseq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DIM_W     = 10,
  parameter int MEM_LO    = 32'h0001_0000,
  parameter int MEM_HI    = 32'h000F_FFFF,
  parameter int HDR_BIG   = 512,
  parameter int HDR_SMALL = 32,
  localparam int IDX_W    = $clog2(PAL_ENTRIES),
  localparam int CMP_W    = ADDR_W + 2 * DIM_W + 4,
  localparam int LS_W     = DIM_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  input  logic [1:0]        loadMode,
  input  logic              dualMode,
  input  logic              tftMode,
  input  logic [DIM_W-1:0]  widthPx,
  input  logic [DIM_W-1:0]  heightPx,
  input  logic              subEn,
  input  logic              subFirst,
  input  logic [DIM_W-1:0]  subLines,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] bot0,
  input  logic [ADDR_W-1:0] top1,
  input  logic [ADDR_W-1:0] bot1,
  input  logic [PAL_DW-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [IDX_W-1:0]  palRdAddr,
  output logic [PAL_DW-1:0] palRdData,
  output logic              running,
  output logic              bufValid,
  output logic              activeBuf,
  output logic              frameShown,
  output logic              paletteDone,
  output logic [2:0]        condPulse,
  output logic              syncErr,
  output logic [ADDR_W-1:0] pixBase,
  output logic [4:0]        bppOut,
  output logic              fmt16,
  output logic [LS_W-1:0]   lineStep,
  output logic [DIM_W-1:0]  firstLine,
  output logic [DIM_W-1:0]  lineCount
);

  // ---- address window check, one comparator pair per boundary ----
  logic [ADDR_W-1:0] chkAddr [4];
  logic [3:0]        inWin;
  assign chkAddr[0] = top0;
  assign chkAddr[1] = bot0;
  assign chkAddr[2] = top1;
  assign chkAddr[3] = bot1;

  for (genvar g = 0; g < 4; g++) begin : g_win
    assign inWin[g] = (chkAddr[g] >= ADDR_W'(MEM_LO)) && (chkAddr[g] <= ADDR_W'(MEM_HI));
  end

  assign stat.addrOk = inWin[0] && inWin[1] && (!dualMode || (inWin[2] && inWin[3]));

  // ---- buffer selection ----
  logic bufSel, bufLive;
  logic [ADDR_W-1:0] actTop, actBot;
  assign actTop = bufSel ? top1 : top0;
  assign actBot = bufSel ? bot1 : bot0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufSel  <= 1'b0;
      bufLive <= 1'b0;
    end else if (strb.stopAll || strb.errAddr || strb.errSync) begin
      bufLive <= 1'b0;
    end else if (strb.beginFrame && !bufLive) begin
      bufSel  <= 1'b0;
      bufLive <= 1'b1;
    end else if (strb.commit && dualMode) begin
      bufSel  <= ~bufSel;
    end
  end

  assign activeBuf = bufSel;
  assign bufValid  = bufLive;

  // ---- palette fetch ----
  logic [IDX_W-1:0] idx;
  logic [2:0]       hdrCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      hdrCode <= '0;
    end else begin
      if (strb.clrIdx)       idx <= '0;
      else if (strb.ldEntry) idx <= idx + 1'b1;
      if (strb.ldEntry && idx == '0) hdrCode <= memRdData[CODE_LSB+2:CODE_LSB];
    end
  end

  assign stat.lastEntry = (idx == IDX_W'(PAL_ENTRIES - 1));
  assign memAddr        = actTop + ADDR_W'({idx, 1'b0});

  lcdseq_palram #(.DEPTH(PAL_ENTRIES), .DW(PAL_DW)) u_palram (
    .clk    (clk),
    .wrEn   (strb.ldEntry),
    .wrAddr (idx),
    .wrData (memRdData),
    .rdAddr (palRdAddr),
    .rdData (palRdData)
  );

  // ---- depth decode and sizing ----
  logic [4:0]        bppComb;
  logic              fmtComb;
  logic [ADDR_W-1:0] offComb;

  always_comb begin
    unique case (hdrCode)
      3'd1:    bppComb = 5'd2;
      3'd2:    bppComb = 5'd4;
      3'd3:    bppComb = 5'd8;
      3'd0:    bppComb = 5'd0;
      default: bppComb = 5'd16;
    endcase
    fmtComb = hdrCode[2] && tftMode;
    if (loadMode == MODE_NOLOAD)  offComb = '0;
    else if (hdrCode >= 3'd3)     offComb = ADDR_W'(HDR_BIG);
    else                          offComb = ADDR_W'(HDR_SMALL);
  end

  assign stat.depthBad = (hdrCode == 3'd0);

  logic [CMP_W-1:0] needComb, roomComb, needReg, roomReg;
  assign needComb = CMP_W'(offComb)
                  + ((CMP_W'(widthPx) * CMP_W'(heightPx) * CMP_W'(bppComb)) >> 3);
  assign roomComb = CMP_W'(actBot) - CMP_W'(actTop) + CMP_W'(2);

  logic [4:0]        bppReg;
  logic              fmtReg;
  logic [ADDR_W-1:0] offReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      needReg <= '0;
      roomReg <= '0;
      bppReg  <= '0;
      fmtReg  <= 1'b0;
      offReg  <= '0;
    end else if (strb.latchCalc) begin
      needReg <= needComb;
      roomReg <= roomComb;
      bppReg  <= bppComb;
      fmtReg  <= fmtComb;
      offReg  <= offComb;
    end
  end

  assign stat.tooBig = $signed(needReg) > $signed(roomReg);

  // ---- published frame parameters ----
  logic [DIM_W+4:0] stepProd;
  assign stepProd = (DIM_W+5)'(widthPx) * (DIM_W+5)'(bppReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixBase   <= '0;
      bppOut    <= '0;
      fmt16     <= 1'b0;
      lineStep  <= '0;
      firstLine <= '0;
      lineCount <= '0;
    end else if (strb.commit) begin
      pixBase   <= actTop + offReg;
      bppOut    <= bppReg;
      fmt16     <= fmtReg;
      lineStep  <= stepProd[DIM_W+4:3];
      firstLine <= (subEn && subFirst) ? subLines : '0;
      lineCount <= (subEn && !subFirst) ? subLines : heightPx;
    end
  end

  // ---- status pulses and levels ----
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameShown  <= 1'b0;
      paletteDone <= 1'b0;
      condPulse   <= '0;
      syncErr     <= 1'b0;
      running     <= 1'b0;
    end else begin
      frameShown   <= strb.commit;
      paletteDone  <= strb.ldEntry && stat.lastEntry;
      condPulse[0] <= strb.commit && !bufSel;
      condPulse[1] <= strb.commit && bufSel;
      condPulse[2] <= strb.errAddr;
      if (strb.stopAll)      syncErr <= 1'b0;
      else if (strb.errSync) syncErr <= 1'b1;
      if (strb.stopAll || strb.errAddr || strb.errSync) running <= 1'b0;
      else if (strb.beginFrame)                         running <= 1'b1;
    end
  end

  p_cond_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(condPulse));

  p_sync_turns_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncErr) |-> (!running && !bufValid));

  p_pal_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    paletteDone |=> !paletteDone);

  p_addr_err_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    condPulse[2] |-> (!running && !frameShown));

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcdseq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DIM_W     = 10,
  parameter int MEM_LO    = 32'h0001_0000,
  parameter int MEM_HI    = 32'h000F_FFFF,
  parameter int HDR_BIG   = 512,
  parameter int HDR_SMALL = 32,
  localparam int IDX_W    = $clog2(PAL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic [1:0]        loadMode,
  input  logic              dualMode,
  input  logic              tftMode,
  input  logic [DIM_W-1:0]  widthPx,
  input  logic [DIM_W-1:0]  heightPx,
  input  logic              subEn,
  input  logic              subFirst,
  input  logic [DIM_W-1:0]  subLines,
  input  logic [ADDR_W-1:0] top0,
  input  logic [ADDR_W-1:0] bot0,
  input  logic [ADDR_W-1:0] top1,
  input  logic [ADDR_W-1:0] bot1,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [15:0]       memRdData,
  input  logic [IDX_W-1:0]  palRdAddr,
  output logic [15:0]       palRdData,
  output logic              busy,
  output logic              running,
  output logic              bufValid,
  output logic              activeBuf,
  output logic              frameShown,
  output logic              paletteDone,
  output logic [2:0]        condPulse,
  output logic              syncErr,
  output logic [ADDR_W-1:0] pixBase,
  output logic [4:0]        bppOut,
  output logic              fmt16,
  output logic [DIM_W+1:0]  lineStep,
  output logic [DIM_W-1:0]  firstLine,
  output logic [DIM_W-1:0]  lineCount
);

  seqStrobe_t strb;
  seqStatus_t stat;

  lcdseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .loadMode   (loadMode),
    .memRdValid (memRdValid),
    .stat       (stat),
    .strb       (strb),
    .memReq     (memReq),
    .busy       (busy)
  );

  lcdseq_dp #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .MEM_LO(MEM_LO), .MEM_HI(MEM_HI),
    .HDR_BIG(HDR_BIG), .HDR_SMALL(HDR_SMALL)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .loadMode    (loadMode),
    .dualMode    (dualMode),
    .tftMode     (tftMode),
    .widthPx     (widthPx),
    .heightPx    (heightPx),
    .subEn       (subEn),
    .subFirst    (subFirst),
    .subLines    (subLines),
    .top0        (top0),
    .bot0        (bot0),
    .top1        (top1),
    .bot1        (bot1),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .palRdAddr   (palRdAddr),
    .palRdData   (palRdData),
    .running     (running),
    .bufValid    (bufValid),
    .activeBuf   (activeBuf),
    .frameShown  (frameShown),
    .paletteDone (paletteDone),
    .condPulse   (condPulse),
    .syncErr     (syncErr),
    .pixBase     (pixBase),
    .bppOut      (bppOut),
    .fmt16       (fmt16),
    .lineStep    (lineStep),
    .firstLine   (firstLine),
    .lineCount   (lineCount)
  );

  p_req_in_header_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ((memAddr - (activeBuf ? top1 : top0)) < ADDR_W'(2 * PAL_ENTRIES)));

endmodule

// File: tb/lcd_frame_seq_test.sv
module lcd_frame_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 0, stopPulse = 0;
  logic [1:0]  loadMode = 0;
  logic        dualMode = 0, tftMode = 0;
  logic [9:0]  widthPx = 10'd8, heightPx = 10'd4;
  logic        subEn = 0, subFirst = 0;
  logic [9:0]  subLines = 0;
  logic [23:0] top0 = 24'h020000, bot0 = 24'h022000;
  logic [23:0] top1 = 24'h040000, bot1 = 24'h042000;
  logic        memReq, memRdValid = 0;
  logic [23:0] memAddr;
  logic [15:0] memRdData = 0;
  logic [7:0]  palRdAddr = 0;
  logic [15:0] palRdData;
  logic        busy, running, bufValid, activeBuf, frameShown, paletteDone, syncErr, fmt16;
  logic [2:0]  condPulse;
  logic [23:0] pixBase;
  logic [4:0]  bppOut;
  logic [11:0] lineStep;
  logic [9:0]  firstLine, lineCount;

  lcd_frame_seq uut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int nFrame = 0, nPal = 0, nReq = 0, nC0 = 0, nC1 = 0, nC2 = 0;
  logic [15:0] hdrWord = 16'h0000;

  function automatic logic [15:0] memWord(logic [23:0] a);
    if (a[8:0] == 9'd0) return hdrWord;
    return a[15:0] ^ 16'hA5C3;
  endfunction

  function automatic int bppOf(int code);
    case (code)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk) begin
    memRdValid <= memReq;
    memRdData  <= memWord(memAddr);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (frameShown)   nFrame++;
      if (paletteDone)  nPal++;
      if (memReq)       nReq++;
      if (condPulse[0]) nC0++;
      if (condPulse[1]) nC1++;
      if (condPulse[2]) nC2++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runFrame();
    int n = 0;
    @(negedge clk) startPulse = 1;
    @(negedge clk) startPulse = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    #1;
    if (n >= 3000) chk(0, "R2 frame timeout", n, 0);
  endtask

  task automatic stopNow();
    @(negedge clk) stopPulse = 1;
    @(negedge clk) stopPulse = 0;
    #1;
  endtask

  initial begin
    #(8 * 190000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0, p0, r0, c0, c1, c2;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && running == 0 && bufValid == 0, "R1 idle flags", {busy, running, bufValid}, 0);
    chk(pixBase == 0 && syncErr == 0 && activeBuf == 0, "R1 outputs", pixBase, 0);
    chk(frameShown == 0 && paletteDone == 0 && condPulse == 0, "R1 pulses", condPulse, 0);

    // R4/R5/R6/R2 sweep over depth codes and packing select
    for (int code = 0; code < 8; code++) begin
      for (int t = 0; t < 2; t++) begin
        int bpp, off;
        hdrWord = 16'(code << 12) | 16'h0123;
        tftMode = t[0];
        f0 = nFrame; p0 = nPal; r0 = nReq; c0 = nC0;
        runFrame();
        bpp = bppOf(code);
        off = (code >= 3) ? 512 : 32;
        chk(nReq - r0 == 256, "R2 read count", nReq - r0, 256);
        chk(nPal - p0 == 1, "R2 palette done once", nPal - p0, 1);
        if (code == 0) begin
          chk(nFrame == f0, "R4 code 0 aborts", nFrame - f0, 0);
        end else begin
          chk(nFrame - f0 == 1 && nC0 - c0 == 1, "R9 frame shown buf0", nC0 - c0, 1);
          chk(bppOut == bpp, "R4 bpp", bppOut, bpp);
          chk(fmt16 == (code >= 4 && t == 1), "R4 fmt16", fmt16, (code >= 4 && t == 1));
          chk(pixBase == top0 + off, "R5 pixBase", pixBase, top0 + off);
          chk(lineStep == (8 * bpp) / 8, "R6 lineStep", lineStep, (8 * bpp) / 8);
          chk(activeBuf == 0, "R9 single stays 0", activeBuf, 0);
        end
      end
    end

    // R2 palette RAM content from last load (buffer 0)
    for (int i = 0; i < 256; i += 51) begin
      logic [15:0] exp;
      exp = memWord(top0 + 24'(2 * i));
      @(negedge clk) palRdAddr = 8'(i);
      @(negedge clk);
      chk(palRdData == exp, "R2 palette entry", palRdData, exp);
    end

    // R3 no-load mode: stored code 7 used, offset 0, no reads
    hdrWord = 16'h1000;
    loadMode = 2; r0 = nReq; p0 = nPal; f0 = nFrame;
    runFrame();
    chk(nReq == r0 && nPal == p0, "R3 no reads in mode 2", nReq - r0, 0);
    chk(nFrame - f0 == 1 && bppOut == 16, "R3 stored depth", bppOut, 16);
    chk(pixBase == top0, "R3 R5 zero offset", pixBase, top0);

    // R3 off mode ignored
    loadMode = 1; r0 = nReq; f0 = nFrame;
    @(negedge clk) startPulse = 1;
    @(negedge clk) startPulse = 0;
    chk(busy == 0, "R3 mode 1 busy", busy, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(nReq == r0 && nFrame == f0, "R3 mode 1 no frame", nFrame - f0, 0);
    loadMode = 2;

    // R11 subpanel
    subEn = 1; subFirst = 1; subLines = 10'd3;
    runFrame();
    chk(firstLine == 3 && lineCount == 4, "R11 first line", firstLine, 3);
    subFirst = 0;
    runFrame();
    chk(firstLine == 0 && lineCount == 3, "R11 line count", lineCount, 3);
    subEn = 0;
    runFrame();
    chk(firstLine == 0 && lineCount == 4, "R11 disabled", lineCount, 4);

    // R10 stop in the commit cycle
    f0 = nFrame;
    @(negedge clk) startPulse = 1;
    @(negedge clk) startPulse = 0;
    @(negedge clk);
    @(negedge clk) stopPulse = 1;
    chk(busy == 1, "R10 busy before stop", busy, 1);
    @(negedge clk) stopPulse = 0;
    #1;
    chk(nFrame == f0 && busy == 0 && bufValid == 0, "R10 stop beats commit", nFrame - f0, 0);
    // R10 start and stop together
    @(negedge clk) begin startPulse = 1; stopPulse = 1; end
    @(negedge clk) begin startPulse = 0; stopPulse = 0; end
    chk(busy == 0, "R10 stop beats start", busy, 1'b0);

    // R9 dual alternation
    dualMode = 1; c0 = nC0; c1 = nC1;
    runFrame();
    chk(pixBase == top1 - top1 + top0 && activeBuf == 1, "R9 dual first buf0", pixBase, top0);
    runFrame();
    chk(pixBase == top1 && activeBuf == 0, "R9 dual second buf1", pixBase, top1);
    runFrame();
    chk(nC0 - c0 == 2 && nC1 - c1 == 1, "R9 cond bits", nC1 - c1, 1);
    stopNow();
    c0 = nC0;
    runFrame();
    chk(nC0 - c0 == 1 && pixBase == top0, "R10 restart at buf0", pixBase, top0);
    stopNow();

    // R8 address checks
    dualMode = 0; top1 = 24'h000100;
    f0 = nFrame;
    runFrame();
    chk(nFrame - f0 == 1, "R8 buf1 unchecked single", nFrame - f0, 1);
    dualMode = 1; c2 = nC2; f0 = nFrame;
    runFrame();
    chk(nC2 - c2 == 1 && running == 0 && nFrame == f0, "R8 dual bad buf1", nC2 - c2, 1);
    dualMode = 0; top1 = 24'h040000; top0 = 24'h000200; loadMode = 0; r0 = nReq; c2 = nC2;
    runFrame();
    chk(nC2 - c2 == 1 && nReq == r0 && bufValid == 0, "R8 bad top0 no reads", nReq - r0, 0);
    top0 = 24'h020000;

    // R7 size boundary: need = 0x200 + 4*4*8/8 = 528
    hdrWord = 16'h3000; widthPx = 10'd4; heightPx = 10'd4;
    bot0 = top0 + 24'd526; f0 = nFrame;
    runFrame();
    chk(nFrame - f0 == 1 && syncErr == 0, "R7 equal accepted", nFrame - f0, 1);
    chk(lineStep == 4, "R6 lineStep 8bpp", lineStep, 4);
    bot0 = top0 + 24'd525; f0 = nFrame;
    runFrame();
    chk(syncErr == 1 && nFrame == f0, "R7 too small", syncErr, 1);
    chk(running == 0 && bufValid == 0, "R7 turns off", running, 0);
    stopNow();
    chk(syncErr == 0, "R10 stop clears syncErr", syncErr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule